// File: doc/BRIEF.md
# Power-up reset time-out sequencer

This block keeps a processor core in reset after power is applied. Once a power-on pulse arrives, it runs two waits back to back. The first is a fixed power-up delay, counted on a slow internal RC clock. The second is an oscillator stabilization count of external oscillator cycles. The second wait is used only with crystal or resonator oscillator modes. Core reset is released when the last wait that applies has finished.

The analog detectors and the oscillators are outside the block. Their results arrive here as digital levels, together with two clocks. The RC-domain delay counter and the oscillator-domain sequencer talk through a request/acknowledge handshake with two-flop synchronizers in each direction.

The block has three other reset sources:
- An active-low master clear input can hold the core in reset past both waits. Once the waits have expired, releasing the pin starts the core at once.
- A brown-out hold request keeps the core in reset and then re-runs the power-up delay.
- A wake request from sleep re-runs only the oscillator count.

Two sticky status flags record whether the last reset came from power-on or from a brown-out. Software sets these flags.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While the power-on pulse is high, and on the first cycle after it ends, `core_rst_o` is 1. Both `pon_flag_o` and `bor_flag_o` read 0 after a power-on pulse.
- R2: Oscillator modes are coded LP=0, XT=1, HS=2 and RC=3. After power-on with the power-up delay enabled and a mode other than RC, reset is held for the delay (PWRT_CYCLES RC-clock periods), then for OST_CYCLES oscillator cycles, and then released.
- R3: In RC mode (3), the oscillator count is skipped. Reset is released after the power-up delay plus synchronizer latency.
- R4: With `pwrt_en_i`=0 and `bor_en_i`=0, power-on runs only the oscillator count. In a mode other than RC, reset falls OST_CYCLES+1 oscillator cycles after the pulse ends.
- R5: With `bor_en_i`=1, the power-up delay runs even when `pwrt_en_i`=0.
- R6: When `mclr_n_i` goes low, `core_rst_o` is 1 two oscillator cycles later, in every state. The time-out sequence keeps running while the pin is low.
- R7: If `mclr_n_i` is raised after both time-outs have expired, `core_rst_o` falls exactly two oscillator cycles later, with no further delay.
- R8: With `bor_en_i`=1, a `bor_hold_i` level forces reset and clears `bor_flag_o`. When the hold ends, the power-up delay runs again and the oscillator count does not. A new hold during that delay restarts it from zero.
- R9: With `bor_en_i`=0, `bor_hold_i` has no effect on `core_rst_o` or on `bor_flag_o`.
- R10: A one-cycle `wake_i` pulse while the core runs does the following:
  - in a mode other than RC, it holds reset for the oscillator count and releases it OST_CYCLES+1 cycles after the pulse;
  - in RC mode it has no effect.
- R11: A `sw_set_pon_i` strobe sets `pon_flag_o`. Only a power-on pulse clears it; master clear and brown-out leave it unchanged.
- R12: A `sw_set_bor_i` strobe sets `bor_flag_o`. It is cleared only when a brown-out reset begins, and master clear leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | External oscillator clock; sequencer and flags domain |
| rc_clk_i | input | 1 | Internal RC clock timing the power-up delay |
| por_i | input | 1 | Power-on pulse, active high, asynchronous reset of the block |
| mclr_n_i | input | 1 | Master clear, active low, asynchronous |
| pwrt_en_i | input | 1 | Power-up delay enable configuration bit |
| bor_en_i | input | 1 | Brown-out reset enable configuration bit |
| osc_mode_i | input | 2 | Oscillator mode: 0 LP, 1 XT, 2 HS, 3 RC |
| wake_i | input | 1 | One-cycle wake-from-sleep request, oscillator domain |
| bor_hold_i | input | 1 | Brown-out comparator level, asynchronous |
| sw_set_pon_i | input | 1 | Software write strobe setting the power-on flag |
| sw_set_bor_i | input | 1 | Software write strobe setting the brown-out flag |
| core_rst_o | output | 1 | Core reset, active high |
| pon_flag_o | output | 1 | Power-on status flag |
| bor_flag_o | output | 1 | Brown-out status flag |

## Verification
Some results pass only through oscillator-domain registers, and each has an exact latency:
- master clear reaches `core_rst_o` two cycles after the pin changes;
- a flag strobe shows one cycle after it;
- a brown-out hold shows three cycles after it;
- a wake pulse releases reset OST_CYCLES+1 cycles later.

The bench samples these results at exactly those cycles, on the falling edge.

Any path that crosses into the RC domain and back varies by a few cycles with clock phase. For these paths the bench counts oscillator cycles until reset falls. It compares that count with a window:
- the lower bound is the nominal delay (PWRT_CYCLES times the clock ratio, plus OST_CYCLES where it applies);
- the upper bound adds synchronizer slack.

Every window is narrower than the smallest difference between modes, so a skipped or added stage falls outside it.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [1:0] {
        OSC_LP = 2'd0,
        OSC_XT = 2'd1,
        OSC_HS = 2'd2,
        OSC_RC = 2'd3
    } osc_mode_e;

    typedef enum logic [2:0] {
        SEQ_START = 3'd0,
        SEQ_PWRT  = 3'd1,
        SEQ_OST   = 3'd2,
        SEQ_RUN   = 3'd3,
        SEQ_BROWN = 3'd4
    } seq_state_e;

    // True when the mode uses a crystal or resonator that needs settling time
    function automatic logic needs_ost(osc_mode_e mode);
        return (mode != OSC_RC);
    endfunction

endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stage_d[g] = d_i;
        end else begin : g_next
            always_comb stage_d[g] = stage_q[g-1];
        end

        always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) stage_q[g] <= RST_VAL;
            else       stage_q[g] <= stage_d[g];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/prs_pwrt_timer.sv
module prs_pwrt_timer #(
    parameter int PWRT_CYCLES = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic rc_clk_i,
    input  logic por_i,
    input  logic req_i,     // level from the oscillator domain
    output logic done_o,    // delay elapsed, RC domain
    output logic ack_o      // RC side still holds state from the last request
);

    localparam int            CW   = $clog2(PWRT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PWRT_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    logic req_s;
    tmr_t tmr_d, tmr_q;

    prs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
        .clk_i (rc_clk_i),
        .rst_i (por_i),
        .d_i   (req_i),
        .q_o   (req_s)
    );

    always_comb begin
        tmr_d = tmr_q;
        if (!req_s) begin
            tmr_d.cnt  = '0;
            tmr_d.done = 1'b0;
        end else if (!tmr_q.done) begin
            if (tmr_q.cnt == LAST) tmr_d.done = 1'b1;
            else                   tmr_d.cnt  = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge rc_clk_i or posedge por_i) begin
        if (por_i) tmr_q <= '0;
        else       tmr_q <= tmr_d;
    end

    assign done_o = tmr_q.done;
    assign ack_o  = req_s | tmr_q.done;

endmodule

// File: rtl/prs_seq_ctrl.sv
module prs_seq_ctrl
    import prs_pkg::*;
#(
    parameter int OST_CYCLES = 1024
) (
    input  logic      clk_i,
    input  logic      por_i,
    input  logic      pwrt_en_i,
    input  logic      bor_en_i,
    input  osc_mode_e mode_i,
    input  logic      bor_s_i,
    input  logic      wake_i,
    input  logic      pwrt_done_s_i,
    input  logic      pwrt_ack_s_i,
    output logic      pwrt_req_o,
    output logic      run_o,
    output logic      brown_entry_o
);

    localparam int            OW   = $clog2(OST_CYCLES + 1);
    localparam logic [OW-1:0] LAST = OW'(OST_CYCLES - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [OW-1:0] ost_cnt;
        logic          ost_after;   // power-on path: oscillator count follows the delay
    } seq_t;

    seq_t seq_d, seq_q;
    logic pwrt_on;
    logic ost_on;
    logic brown_now;

    assign pwrt_on   = pwrt_en_i | bor_en_i;
    assign ost_on    = needs_ost(mode_i);
    assign brown_now = bor_en_i & bor_s_i;

    always_comb begin
        seq_d         = seq_q;
        brown_entry_o = 1'b0;
        if (brown_now && seq_q.state != SEQ_BROWN) begin
            seq_d.state     = SEQ_BROWN;
            seq_d.ost_cnt   = '0;
            seq_d.ost_after = 1'b0;
            brown_entry_o   = 1'b1;
        end else begin
            unique case (seq_q.state)
                SEQ_START: begin
                    seq_d.ost_cnt = '0;
                    if (pwrt_on)     seq_d.state = SEQ_PWRT;
                    else if (ost_on) seq_d.state = SEQ_OST;
                    else             seq_d.state = SEQ_RUN;
                end
                SEQ_PWRT: begin
                    if (pwrt_done_s_i) begin
                        seq_d.ost_cnt = '0;
                        if (seq_q.ost_after && ost_on) seq_d.state = SEQ_OST;
                        else                           seq_d.state = SEQ_RUN;
                    end
                end
                SEQ_OST: begin
                    if (seq_q.ost_cnt == LAST) seq_d.state   = SEQ_RUN;
                    else                       seq_d.ost_cnt = seq_q.ost_cnt + 1'b1;
                end
                SEQ_RUN: begin
                    if (wake_i && ost_on) begin
                        seq_d.state   = SEQ_OST;
                        seq_d.ost_cnt = '0;
                    end
                end
                SEQ_BROWN: begin
                    // leave only once the RC side has dropped the old request
                    if (!brown_now && !pwrt_ack_s_i) seq_d.state = SEQ_PWRT;
                end
                default: seq_d.state = SEQ_START;
            endcase
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            seq_q.state     <= SEQ_START;
            seq_q.ost_cnt   <= '0;
            seq_q.ost_after <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pwrt_req_o = (seq_q.state == SEQ_PWRT);
    assign run_o      = (seq_q.state == SEQ_RUN);

endmodule

// File: rtl/prs_flags.sv
module prs_flags (
    input  logic clk_i,
    input  logic por_i,
    input  logic sw_set_pon_i,
    input  logic sw_set_bor_i,
    input  logic brown_entry_i,
    output logic pon_flag_o,
    output logic bor_flag_o
);

    typedef struct packed {
        logic pon;
        logic bor;
    } flag_t;

    flag_t flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (sw_set_pon_i) flag_d.pon = 1'b1;
        if (brown_entry_i)     flag_d.bor = 1'b0;
        else if (sw_set_bor_i) flag_d.bor = 1'b1;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) flag_q <= '0;
        else       flag_q <= flag_d;
    end

    assign pon_flag_o = flag_q.pon;
    assign bor_flag_o = flag_q.bor;

endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
    import prs_pkg::*;
#(
    parameter int PWRT_CYCLES = 2048,
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       osc_clk_i,
    input  logic       rc_clk_i,
    input  logic       por_i,
    input  logic       mclr_n_i,
    input  logic       pwrt_en_i,
    input  logic       bor_en_i,
    input  logic [1:0] osc_mode_i,
    input  logic       wake_i,
    input  logic       bor_hold_i,
    input  logic       sw_set_pon_i,
    input  logic       sw_set_bor_i,
    output logic       core_rst_o,
    output logic       pon_flag_o,
    output logic       bor_flag_o
);

    logic       mclr_ok;
    logic       bor_s;
    logic       pwrt_req;
    logic       pwrt_done_rc;
    logic       pwrt_ack_rc;
    logic [1:0] back_s;
    logic       seq_run;
    logic       brown_entry;
    osc_mode_e  mode;

    assign mode = osc_mode_e'(osc_mode_i);

    prs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mclr_sync (
        .clk_i (osc_clk_i),
        .rst_i (por_i),
        .d_i   (mclr_n_i),
        .q_o   (mclr_ok)
    );

    prs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bor_sync (
        .clk_i (osc_clk_i),
        .rst_i (por_i),
        .d_i   (bor_hold_i),
        .q_o   (bor_s)
    );

    prs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_back_sync (
        .clk_i (osc_clk_i),
        .rst_i (por_i),
        .d_i   ({pwrt_done_rc, pwrt_ack_rc}),
        .q_o   (back_s)
    );

    prs_pwrt_timer #(.PWRT_CYCLES(PWRT_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_pwrt (
        .rc_clk_i (rc_clk_i),
        .por_i    (por_i),
        .req_i    (pwrt_req),
        .done_o   (pwrt_done_rc),
        .ack_o    (pwrt_ack_rc)
    );

    prs_seq_ctrl #(.OST_CYCLES(OST_CYCLES)) u_ctrl (
        .clk_i         (osc_clk_i),
        .por_i         (por_i),
        .pwrt_en_i     (pwrt_en_i),
        .bor_en_i      (bor_en_i),
        .mode_i        (mode),
        .bor_s_i       (bor_s),
        .wake_i        (wake_i),
        .pwrt_done_s_i (back_s[1]),
        .pwrt_ack_s_i  (back_s[0]),
        .pwrt_req_o    (pwrt_req),
        .run_o         (seq_run),
        .brown_entry_o (brown_entry)
    );

    prs_flags u_flags (
        .clk_i         (osc_clk_i),
        .por_i         (por_i),
        .sw_set_pon_i  (sw_set_pon_i),
        .sw_set_bor_i  (sw_set_bor_i),
        .brown_entry_i (brown_entry),
        .pon_flag_o    (pon_flag_o),
        .bor_flag_o    (bor_flag_o)
    );

    assign core_rst_o = ~(seq_run & mclr_ok);

endmodule

// File: rtl/prs_checker.sv
module prs_checker (
    input logic osc_clk_i,
    input logic por_i,
    input logic mclr_n_i,
    input logic bor_en_i,
    input logic bor_s,
    input logic sw_set_pon_i,
    input logic sw_set_bor_i,
    input logic core_rst_o,
    input logic pon_flag_o,
    input logic bor_flag_o
);

    p_mclr_forces_r6: assert property (@(posedge osc_clk_i) disable iff (por_i)
        (!$past(mclr_n_i) && !$past(mclr_n_i, 2)) |-> core_rst_o);

    p_mclr_release_r7: assert property (@(posedge osc_clk_i) disable iff (por_i)
        $fell(core_rst_o) |-> $past(mclr_n_i, 2));

    p_brown_hold_r8: assert property (@(posedge osc_clk_i) disable iff (por_i)
        (bor_en_i && bor_s) |=> core_rst_o);

    p_bor_clear_in_reset_r8: assert property (@(posedge osc_clk_i) disable iff (por_i)
        $fell(bor_flag_o) |-> core_rst_o);

    p_pon_set_r11: assert property (@(posedge osc_clk_i) disable iff (por_i)
        $rose(pon_flag_o) |-> $past(sw_set_pon_i));

    p_pon_no_clear_r11: assert property (@(posedge osc_clk_i) disable iff (por_i)
        !$fell(pon_flag_o));

    p_bor_set_r12: assert property (@(posedge osc_clk_i) disable iff (por_i)
        $rose(bor_flag_o) |-> $past(sw_set_bor_i));

endmodule

bind pwrup_rst_seq prs_checker u_chk (
    .osc_clk_i    (osc_clk_i),
    .por_i        (por_i),
    .mclr_n_i     (mclr_n_i),
    .bor_en_i     (bor_en_i),
    .bor_s        (bor_s),
    .sw_set_pon_i (sw_set_pon_i),
    .sw_set_bor_i (sw_set_bor_i),
    .core_rst_o   (core_rst_o),
    .pon_flag_o   (pon_flag_o),
    .bor_flag_o   (bor_flag_o)
);

// File: tb/pwrup_rst_seq_tb.sv
module pwrup_rst_seq_tb;

    localparam int PWRT = 20;
    localparam int OST  = 32;
    localparam int RATIO = 4;              // RC period / oscillator period
    localparam int DLY  = PWRT * RATIO;    // nominal delay in oscillator cycles

    logic       osc_clk = 1'b0;
    logic       rc_clk  = 1'b0;
    logic       por = 1'b1;
    logic       mclr_n = 1'b1;
    logic       pwrt_en = 1'b1;
    logic       bor_en = 1'b0;
    logic [1:0] mode = 2'd1;
    logic       wake = 1'b0;
    logic       bor_hold = 1'b0;
    logic       set_pon = 1'b0;
    logic       set_bor = 1'b0;
    logic       core_rst;
    logic       pon_flag;
    logic       bor_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 osc_clk = ~osc_clk;   // 50 MHz
    always #40 rc_clk  = ~rc_clk;

    pwrup_rst_seq #(.PWRT_CYCLES(PWRT), .OST_CYCLES(OST)) u_dut (
        .osc_clk_i    (osc_clk),
        .rc_clk_i     (rc_clk),
        .por_i        (por),
        .mclr_n_i     (mclr_n),
        .pwrt_en_i    (pwrt_en),
        .bor_en_i     (bor_en),
        .osc_mode_i   (mode),
        .wake_i       (wake),
        .bor_hold_i   (bor_hold),
        .sw_set_pon_i (set_pon),
        .sw_set_bor_i (set_bor),
        .core_rst_o   (core_rst),
        .pon_flag_o   (pon_flag),
        .bor_flag_o   (bor_flag)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=[%0d,%0d]", req, act, lo, hi);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge osc_clk);
    endtask

    task automatic do_por(input logic pe, input logic be, input logic [1:0] md, input logic mc);
        @(negedge osc_clk);
        por = 1'b1; pwrt_en = pe; bor_en = be; mode = md; mclr_n = mc;
        wake = 1'b0; bor_hold = 1'b0; set_pon = 1'b0; set_bor = 1'b0;
        step(3);
        por = 1'b0;
    endtask

    task automatic cycles_to_release(output int n);
        n = 0;
        while (core_rst && n < 3000) begin
            @(negedge osc_clk);
            n++;
        end
    endtask

    task automatic sw_set_both();
        set_pon = 1'b1; set_bor = 1'b1;
        step(1);
        set_pon = 1'b0; set_bor = 1'b0;
    endtask

    task automatic t_reset_state();
        do_por(1'b1, 1'b0, 2'd1, 1'b1);
        chk_eq("R1 core_rst after por", int'(core_rst), 1);
        step(1);
        chk_eq("R1 core_rst first cycle", int'(core_rst), 1);
        chk_eq("R1 pon_flag", int'(pon_flag), 0);
        chk_eq("R1 bor_flag", int'(bor_flag), 0);
    endtask

    task automatic t_por_full();
        int n;
        do_por(1'b1, 1'b0, 2'd1, 1'b1);
        cycles_to_release(n);
        chk_rng("R2 XT delay+count", n, DLY + OST, DLY + OST + 24);
        do_por(1'b1, 1'b0, 2'd2, 1'b1);
        cycles_to_release(n);
        chk_rng("R2 HS delay+count", n, DLY + OST, DLY + OST + 24);
    endtask

    task automatic t_por_rc();
        int n;
        do_por(1'b1, 1'b0, 2'd3, 1'b1);
        cycles_to_release(n);
        chk_rng("R3 RC skips count", n, DLY, DLY + 24);
    endtask

    task automatic t_no_pwrt();
        int n;
        do_por(1'b0, 1'b0, 2'd0, 1'b1);
        cycles_to_release(n);
        chk_eq("R4 count only", n, OST + 1);
    endtask

    task automatic t_forced_pwrt();
        int n;
        do_por(1'b0, 1'b1, 2'd3, 1'b1);
        cycles_to_release(n);
        chk_rng("R5 delay forced by brown-out enable", n, DLY, DLY + 24);
    endtask

    task automatic t_mclr_run();
        int n;
        do_por(1'b1, 1'b0, 2'd1, 1'b1);
        cycles_to_release(n);
        sw_set_both();
        mclr_n = 1'b0;
        step(1);
        chk_eq("R6 one cycle after mclr low", int'(core_rst), 0);
        step(1);
        chk_eq("R6 two cycles after mclr low", int'(core_rst), 1);
        step(10);
        mclr_n = 1'b1;
        step(1);
        chk_eq("R7 one cycle after mclr high", int'(core_rst), 1);
        step(1);
        chk_eq("R7 two cycles after mclr high", int'(core_rst), 0);
        chk_eq("R11 pon kept over mclr", int'(pon_flag), 1);
        chk_eq("R12 bor kept over mclr", int'(bor_flag), 1);
    endtask

    task automatic t_mclr_hold();
        do_por(1'b1, 1'b0, 2'd1, 1'b0);
        step(DLY + OST + 60);
        chk_eq("R6 mclr holds past time-outs", int'(core_rst), 1);
        mclr_n = 1'b1;
        step(1);
        chk_eq("R7 release one cycle", int'(core_rst), 1);
        step(1);
        chk_eq("R7 immediate release", int'(core_rst), 0);
    endtask

    task automatic t_brown();
        int n;
        do_por(1'b1, 1'b1, 2'd1, 1'b1);
        cycles_to_release(n);
        sw_set_both();
        bor_hold = 1'b1;
        step(2);
        chk_eq("R8 no reset before sync", int'(core_rst), 0);
        step(1);
        chk_eq("R8 brown-out reset", int'(core_rst), 1);
        chk_eq("R8 bor flag cleared", int'(bor_flag), 0);
        chk_eq("R11 pon kept over brown-out", int'(pon_flag), 1);
        step(30);
        bor_hold = 1'b0;
        cycles_to_release(n);
        chk_rng("R8 delay without count", n, DLY + 2, DLY + 30);
        // restart: new hold in the middle of the delay
        bor_hold = 1'b1;
        step(20);
        bor_hold = 1'b0;
        step(40);
        bor_hold = 1'b1;
        step(20);
        chk_eq("R8 held during repeat hold", int'(core_rst), 1);
        bor_hold = 1'b0;
        cycles_to_release(n);
        chk_rng("R8 delay restarts", n, DLY + 2, DLY + 30);
    endtask

    task automatic t_bor_off();
        int n;
        do_por(1'b1, 1'b0, 2'd1, 1'b1);
        cycles_to_release(n);
        sw_set_both();
        bor_hold = 1'b1;
        step(20);
        chk_eq("R9 hold ignored reset", int'(core_rst), 0);
        chk_eq("R9 hold ignored flag", int'(bor_flag), 1);
        bor_hold = 1'b0;
        step(3);
    endtask

    task automatic t_wake();
        int n;
        do_por(1'b1, 1'b0, 2'd1, 1'b1);
        cycles_to_release(n);
        wake = 1'b1;
        step(1);
        wake = 1'b0;
        chk_eq("R10 wake asserts reset", int'(core_rst), 1);
        cycles_to_release(n);
        chk_eq("R10 wake count length", n + 1, OST + 1);
        do_por(1'b1, 1'b0, 2'd3, 1'b1);
        cycles_to_release(n);
        wake = 1'b1;
        step(1);
        wake = 1'b0;
        step(4);
        chk_eq("R10 wake ignored in RC", int'(core_rst), 0);
    endtask

    task automatic t_por_flags();
        int n;
        do_por(1'b1, 1'b0, 2'd1, 1'b1);
        cycles_to_release(n);
        sw_set_both();
        chk_eq("R11 pon set by write", int'(pon_flag), 1);
        chk_eq("R12 bor set by write", int'(bor_flag), 1);
        do_por(1'b1, 1'b0, 2'd1, 1'b1);
        step(1);
        chk_eq("R11 pon cleared by por", int'(pon_flag), 0);
    endtask

    initial begin
        t_reset_state();
        t_por_full();
        t_por_rc();
        t_no_pwrt();
        t_forced_pwrt();
        t_mclr_run();
        t_mclr_hold();
        t_brown();
        t_bor_off();
        t_wake();
        t_por_flags();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge osc_clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule